// File: doc/BRIEF.md
# Two-Channel Edge-to-Pulse Isolation Encoder with Level Refresh

This block is the sending half of a two-channel digital isolation link, modelled as clocked logic. Each channel samples a logic input through a two-stage synchroniser. A rising level becomes a single-cycle pulse on that channel's set line. A falling level becomes a single-cycle pulse on its clear line. The far side only has to remember which of the two lines pulsed last.

A pulse can be lost, or the receiver can start up after the last edge. To cover both cases, each channel keeps a refresh timer. When the input has not moved for one refresh period, the channel sends a pulse that repeats the present level. The receiver therefore converges to the correct level even for a DC input.

The refresh period is given in nanoseconds together with the clock rate in MHz, and is converted to a whole number of cycles. A power input models the input-side supply. While it is low the channel sends nothing. Once it returns, a refresh restores the far side within one period.

Top module: `iso_pulse_tx`

## Requirements
- R1: A rising change on `din_i[c]` gives a pulse on `set_o[c]` one cycle wide. The pulse appears in the third clock cycle after the change: two synchroniser stages, then the output register.
- R2: A falling change on `din_i[c]` gives a one-cycle pulse on `clr_o[c]`, with the same three-cycle latency as R1.
- R3: Every pulse is exactly one cycle wide, and `set_o[c]` and `clr_o[c]` are never high in the same cycle.
- R4: With power on and the input steady, a channel sends a refresh pulse every REFRESH_CYC cycles, counted from its previous pulse. The refresh goes on `set_o` when the synchronised level is 1 and on `clr_o` when it is 0. REFRESH_CYC = ceil(CLK_MHZ*REFRESH_NS/1000), which is 88 cycles with the defaults.
- R5: Any edge pulse restarts that channel's refresh schedule. When an edge pulse and a refresh fall due in the same cycle, only the edge pulse is sent.
- R6: An input level held for a single clock cycle still produces both of its edge pulses, in consecutive cycles.
- R7: The two channels are independent. Activity on one channel does not move the pulses or the refresh schedule of the other.
- R8: From the cycle after `pwr_i` is sampled low, no pulse is sent. Input changes made while power is low produce no edge pulse later.
- R9: After `pwr_i` returns high, the first refresh carrying the current level comes REFRESH_CYC-1 cycles after the first clock edge that samples it high. That is within one refresh period.
- R10: `rst_i` is synchronous and active high. During reset both outputs are low. After reset is released, the block behaves as after a power return (R9).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, CLK_MHZ MHz |
| rst_i | input | 1 | Synchronous active-high reset |
| pwr_i | input | 1 | Input-side supply present; low silences all channels |
| din_i | input | NCH | Asynchronous logic inputs, one per channel |
| set_o | output | NCH | One-cycle pulse: level is now 1 (edge or refresh) |
| clr_o | output | NCH | One-cycle pulse: level is now 0 (edge or refresh) |

## Verification
The faults that matter here are timing faults, not visible ones. A refresh counter that is off by one, or that misses a restart, shows up as a refresh pulse one or more cycles away from the expected slot. That becomes visible within one refresh period of the last edge. A stale edge-detect register shows up as a spurious pulse three cycles after a power return, or a missing pulse three cycles after an input change. A refresh that reads the wrong level shows up as a pulse of the wrong kind in the first refresh slot. The bench therefore compares every pulse by cycle number and kind, and treats any unscheduled pulse as an error.

// File: rtl/iso_pulse_pkg.sv
package iso_pulse_pkg;

    // What a channel puts on its two pulse lines in a given cycle
    typedef enum logic [1:0] {
        PK_NONE = 2'b00,
        PK_SET  = 2'b01,
        PK_CLR  = 2'b10
    } pulse_kind_e;

    // Synchronised level plus the edges seen against the previous sample
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } edge_info_t;

    // Refresh period in whole clock cycles, rounded up
    function automatic int unsigned period_cycles(input int unsigned clk_mhz,
                                                  input int unsigned per_ns);
        return (clk_mhz * per_ns + 999) / 1000;
    endfunction

    // Pulse kind that restates a static level
    function automatic pulse_kind_e level_kind(input logic lvl);
        return lvl ? PK_SET : PK_CLR;
    endfunction

endpackage

// File: rtl/iso_sync2.sv
module iso_sync2 #(
    parameter int unsigned W = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/iso_edge_det.sv
module iso_edge_det
    import iso_pulse_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       lvl_i,
    output edge_info_t info_o
);
    logic prev_q;

    // The previous sample follows the input even without power,
    // so changes made while unpowered never turn into late edges.
    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= 1'b0;
        else       prev_q <= lvl_i;
    end

    always_comb begin
        info_o.lvl  = lvl_i;
        info_o.rise = lvl_i & ~prev_q;
        info_o.fall = ~lvl_i & prev_q;
    end
endmodule

// File: rtl/iso_refresh_tmr.sv
module iso_refresh_tmr #(
    parameter int unsigned PERIOD = 88
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    input  logic restart_i,
    output logic due_o
);
    localparam int unsigned CW   = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam int unsigned LAST = PERIOD - 1;

    logic [CW-1:0] cnt_q;

    assign due_o = (cnt_q == CW'(LAST));

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i || restart_i || due_o) cnt_q <= '0;
        else                                        cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/iso_chan_enc.sv
module iso_chan_enc
    import iso_pulse_pkg::*;
#(
    parameter int unsigned REFRESH_CYC = 88
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pwr_i,
    input  logic lvl_i,
    output logic set_o,
    output logic clr_o
);
    edge_info_t  info;
    logic        due;
    pulse_kind_e kind_d;
    pulse_kind_e kind_q;

    iso_edge_det u_edge (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .lvl_i  (lvl_i),
        .info_o (info)
    );

    iso_refresh_tmr #(.PERIOD(REFRESH_CYC)) u_tmr (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .run_i     (pwr_i),
        .restart_i (info.rise | info.fall),
        .due_o     (due)
    );

    // Edges take precedence over refresh; nothing leaves without power
    always_comb begin
        kind_d = PK_NONE;
        if (pwr_i) begin
            if (info.rise)      kind_d = PK_SET;
            else if (info.fall) kind_d = PK_CLR;
            else if (due)       kind_d = level_kind(info.lvl);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) kind_q <= PK_NONE;
        else       kind_q <= kind_d;
    end

    assign set_o = (kind_q == PK_SET);
    assign clr_o = (kind_q == PK_CLR);
endmodule

// File: rtl/iso_pulse_tx.sv
module iso_pulse_tx
    import iso_pulse_pkg::*;
#(
    parameter int unsigned NCH        = 2,
    parameter int unsigned CLK_MHZ    = 100,
    parameter int unsigned REFRESH_NS = 880
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           pwr_i,
    input  logic [NCH-1:0] din_i,
    output logic [NCH-1:0] set_o,
    output logic [NCH-1:0] clr_o
);
    localparam int unsigned REFRESH_CYC = period_cycles(CLK_MHZ, REFRESH_NS);

    logic [NCH-1:0] lvl;

    iso_sync2 #(.W(NCH)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (din_i),
        .q_o   (lvl)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        iso_chan_enc #(.REFRESH_CYC(REFRESH_CYC)) u_enc (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .pwr_i (pwr_i),
            .lvl_i (lvl[c]),
            .set_o (set_o[c]),
            .clr_o (clr_o[c])
        );
    end
endmodule

// File: rtl/iso_pulse_tx_chk.sv
module iso_pulse_tx_chk
    import iso_pulse_pkg::*;
#(
    parameter int unsigned NCH        = 2,
    parameter int unsigned CLK_MHZ    = 100,
    parameter int unsigned REFRESH_NS = 880
) (
    input logic           clk_i,
    input logic           rst_i,
    input logic           pwr_i,
    input logic [NCH-1:0] set_o,
    input logic [NCH-1:0] clr_o
);
    localparam int unsigned RC = period_cycles(CLK_MHZ, REFRESH_NS);
    localparam int unsigned GW = $clog2(RC + 2) + 1;

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // Cycles since this channel last pulsed while powered
        logic [GW-1:0] gap_q;
        always_ff @(posedge clk_i) begin
            if (rst_i || !pwr_i || set_o[c] || clr_o[c]) gap_q <= '0;
            else                                          gap_q <= gap_q + 1'b1;
        end

        AST_SET_CLR_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
            !(set_o[c] && clr_o[c])); // R3
        AST_SET_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
            set_o[c] |=> !set_o[c]); // R3
        AST_CLR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
            clr_o[c] |=> !clr_o[c]); // R3
        AST_SILENT_UNPOWERED: assert property (@(posedge clk_i) disable iff (rst_i)
            !pwr_i |=> (!set_o[c] && !clr_o[c])); // R8
        AST_REFRESH_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
            gap_q <= GW'(RC)); // R4 R9
    end
endmodule

bind iso_pulse_tx iso_pulse_tx_chk #(
    .NCH        (NCH),
    .CLK_MHZ    (CLK_MHZ),
    .REFRESH_NS (REFRESH_NS)
) u_chk (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .pwr_i (pwr_i),
    .set_o (set_o),
    .clr_o (clr_o)
);

// File: tb/sim_iso_pulse_tx.sv
module sim_iso_pulse_tx;
    localparam int R       = 88;     // 880 ns at a 10 ns clock
    localparam int HORIZON = 6000;

    typedef struct {
        int    at;
        bit    kind;                 // 1 = set pulse, 0 = clear pulse
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr = 1'b1;
    logic [1:0] din = 2'b00;
    logic [1:0] set_w;
    logic [1:0] clr_w;

    int    cyc    = 0;
    int    checks = 0;
    int    errors = 0;
    exp_t  q0[$];
    exp_t  q1[$];
    bit    lvl[2];
    int    pulses[2];
    string cur_tag = "R10";

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    iso_pulse_tx #(.NCH(2), .CLK_MHZ(100), .REFRESH_NS(880)) u0 (
        .clk_i (clk),
        .rst_i (rst),
        .pwr_i (pwr),
        .din_i (din),
        .set_o (set_w),
        .clr_o (clr_w)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d",
                     tag, what, cyc, act, exp);
        end
    endtask

    task automatic push(input int c, input int at, input bit k, input string tag);
        exp_t e;
        e.at = at; e.kind = k; e.tag = tag;
        if (c == 0) q0.push_back(e);
        else        q1.push_back(e);
    endtask

    task automatic trim(input int c, input int cutoff);
        if (c == 0) while (q0.size() > 0 && q0[$].at >= cutoff) void'(q0.pop_back());
        else        while (q1.size() > 0 && q1[$].at >= cutoff) void'(q1.pop_back());
    endtask

    // Refresh slots follow from R4: every R cycles at the held level
    task automatic sched(input int c, input int start, input string tag);
        for (int t = start; t <= HORIZON; t += R) push(c, t, lvl[c], tag);
    endtask

    // Edge pulse 3 cycles after the change (R1/R2), schedule restarts (R5)
    task automatic edge_to(input int c, input bit v, input string tag);
        din[c] = v;
        lvl[c] = v;
        cur_tag = tag;
        if (pwr) begin
            trim(c, cyc + 3);
            push(c, cyc + 3, v, tag);
            sched(c, cyc + 3 + R, "R5");
        end
    endtask

    task automatic power(input bit on);
        pwr = on;
        for (int c = 0; c < 2; c++) begin
            if (on) sched(c, cyc + R, "R9");
            else    trim(c, cyc + 1);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mon(ref exp_t q[$], input int c);
        bit s;
        bit r;
        s = set_w[c];
        r = clr_w[c];
        while (q.size() > 0 && q[0].at < cyc) begin
            check(1'b0, q[0].tag, "missing pulse, expected at cycle", cyc, q[0].at);
            void'(q.pop_front());
        end
        if (s || r) begin
            pulses[c]++;
            check(!(s && r), "R3", "set and clear together", 2, 1);
            if (q.size() > 0 && q[0].at == cyc) begin
                check(s == q[0].kind, q[0].tag, "pulse kind (1=set)", s, q[0].kind);
                void'(q.pop_front());
            end else begin
                check(1'b0, cur_tag, "unexpected pulse, kind (1=set)", s, -1);
            end
        end
    endtask

    always @(negedge clk) begin
        mon(q0, 0);
        mon(q1, 1);
    end

    initial begin
        wait (cyc > 20000);
        checks++;
        errors++;
        $display("FAIL R4 watchdog expired: actual %0d expected below %0d", cyc, 20000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int e;
        int snap0;
        int snap1;
        wait_cyc(3);
        check(set_w == 2'b00 && clr_w == 2'b00, "R10", "outputs in reset", {set_w, clr_w}, 0);
        wait_cyc(2);
        check(set_w == 2'b00 && clr_w == 2'b00, "R10", "outputs in reset", {set_w, clr_w}, 0);
        rst = 1'b0;
        cur_tag = "R10";
        sched(0, cyc + R, "R10");
        sched(1, cyc + R, "R10");
        wait_cyc(200);

        edge_to(0, 1'b1, "R1");
        wait_cyc(30);
        edge_to(0, 1'b0, "R2");
        wait_cyc(200);
        cur_tag = "R4";
        edge_to(0, 1'b1, "R1");
        e = cyc;
        // Edge pulse lands exactly on the second refresh slot (R5)
        while (cyc < e + 2 * R) @(negedge clk);
        edge_to(0, 1'b0, "R5");
        wait_cyc(50);
        edge_to(0, 1'b1, "R5");
        wait_cyc(120);

        // Single-cycle levels on ch0, ch1 moves alongside (R6, R7)
        for (int i = 0; i < 6; i++) begin
            edge_to(0, !lvl[0], "R6");
            if (i == 2) edge_to(1, 1'b1, "R7");
            wait_cyc(1);
        end
        wait_cyc(150);
        edge_to(1, 1'b0, "R7");
        wait_cyc(100);

        // Power loss: silence, input changes swallowed (R8)
        power(1'b0);
        cur_tag = "R8";
        wait_cyc(1);
        #1;
        snap0 = pulses[0];
        snap1 = pulses[1];
        wait_cyc(10);
        edge_to(0, 1'b0, "R8");
        edge_to(1, 1'b1, "R8");
        wait_cyc(20);
        edge_to(0, 1'b1, "R8");
        wait_cyc(250);
        #1;
        check(pulses[0] == snap0, "R8", "ch0 pulses while unpowered", pulses[0] - snap0, 0);
        check(pulses[1] == snap1, "R8", "ch1 pulses while unpowered", pulses[1] - snap1, 0);
        @(negedge clk);

        // Power return: refresh at the current level within one period (R9)
        power(1'b1);
        cur_tag = "R9";
        wait_cyc(250);

        trim(0, cyc + 1);
        trim(1, cyc + 1);
        wait_cyc(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule